// File: doc/BRIEF.md
# Temperature-Aware DRAM Refresh Pacer

This block paces auto-refresh work for a DRAM controller. An interval timer counts controller clock cycles and, at the end of each interval, adds one owed refresh to a small backlog. The interval is derived at elaboration time from the controller clock period. There are two settings. The normal setting targets 8192 refreshes per 64 ms, about 7.8 µs each. The hot setting targets 8192 refreshes per 32 ms, about 3.9 µs each. A case-temperature flag picks the setting while the block runs. When the flag rises part way through an interval, the running count is cut down so that the current interval cannot outlast the hot limit.

A refresh may only be sent while every bank is idle. The pacer therefore raises its request only when refreshes are owed and the controller reports all banks idle. The request stays high until the command arbiter grants it. Each grant retires one owed refresh. Refreshes can be deferred while banks are busy. Once the backlog reaches its limit, the block raises a stall so that the arbiter gives priority to refresh.

Top module: `refresh_pacer`

## Requirements
- R1: After reset, and whenever the hot flag is low, one refresh is added to the backlog every NORM_INTERVAL_NS / CLK_PERIOD_NS clock edges (78 with the default parameters). The first is added on the 78th rising edge after reset is released.
- R2: While the hot flag is high, the interval is HOT_INTERVAL_NS / CLK_PERIOD_NS edges (39 with the default parameters).
- R3: If the hot flag is high while the count remaining in the current interval exceeds the hot limit, the remaining count is set to the hot limit on that edge. For example, a hot flag raised after 10 cold edges yields a backlog entry on edge 50 instead of edge 78.
- R4: refReq is high exactly when the backlog is non-zero and banksIdle is high, with no register between banksIdle and refReq.
- R5: A refGrant sampled while refReq is high lowers the backlog by one. A refGrant sampled while refReq is low has no effect. refReq stays high until the backlog is empty.
- R6: The backlog never exceeds MAX_PENDING (8). An interval that ends while the backlog is full adds nothing.
- R7: refStall is high exactly when the backlog equals MAX_PENDING.
- R8: If an interval ends on the same edge that a grant is taken, the backlog is unchanged.
- R9: While rstN is low, the backlog is 0 and refReq and refStall are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hotCase | input | 1 | Case temperature above threshold; selects the short interval |
| banksIdle | input | 1 | All banks are precharged and idle |
| refGrant | input | 1 | Arbiter accepts the refresh request this cycle |
| refReq | output | 1 | Refresh requested |
| pendCount | output | $clog2(MAX_PENDING+1) | Refreshes owed (backlog) |
| refStall | output | 1 | Backlog full; refresh is urgent |

## Verification
The end of an interval and the acceptance of a grant can fall on the same clock edge. In that case the backlog must neither grow nor shrink. The bench provokes this by counting edges from reset release to the known end of the second cold interval, edge 156. It holds banksIdle and refGrant high for exactly that edge and then checks that the backlog still reads one and that the request is still raised. Saturation is provoked the same way: with no grants, the bench checks that the ninth interval end leaves a full backlog at eight.

// File: rtl/refresh_pacer_pkg.sv
package refresh_pacer_pkg;
  typedef struct packed {
    logic tick;   // interval elapsed this cycle
    logic take;   // grant accepted this cycle
  } pacerStrobes_t;
endpackage

// File: rtl/pacer_ctrl.sv
module pacer_ctrl
  import refresh_pacer_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 100,
  parameter int NORM_INTERVAL_NS = 7800,
  parameter int HOT_INTERVAL_NS  = 3900
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hotCase,
  input  logic          banksIdle,
  input  logic          refGrant,
  input  logic          pendAny,
  output logic          refReq,
  output pacerStrobes_t strobes
);
  localparam int NORM_LIM = NORM_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int HOT_LIM  = HOT_INTERVAL_NS / CLK_PERIOD_NS;
  localparam int TW       = $clog2(NORM_LIM + 1);
  localparam logic [TW-1:0] NORM_TOP = TW'(NORM_LIM - 1);
  localparam logic [TW-1:0] HOT_TOP  = TW'(HOT_LIM - 1);

  logic [TW-1:0] remain;
  logic [TW-1:0] remainNext;

  always_comb begin
    if (remain == '0)
      remainNext = hotCase ? HOT_TOP : NORM_TOP;
    else if (hotCase && (remain > HOT_TOP))
      remainNext = HOT_TOP;
    else
      remainNext = remain - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) remain <= NORM_TOP;
    else       remain <= remainNext;
  end

  assign refReq       = pendAny & banksIdle;
  assign strobes.tick = (remain == '0);
  assign strobes.take = refReq & refGrant;
endmodule

// File: rtl/pacer_dp.sv
module pacer_dp
  import refresh_pacer_pkg::*;
#(
  parameter int MAX_PENDING = 8,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  pacerStrobes_t strobes,
  output logic [PW-1:0] pendCount,
  output logic          pendAny,
  output logic          refStall
);
  localparam logic [PW-1:0] FULL = PW'(MAX_PENDING);

  logic [PW-1:0] backlog;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      backlog <= '0;
    end else begin
      unique case ({strobes.tick, strobes.take})
        2'b10:   if (backlog != FULL) backlog <= backlog + 1'b1;
        2'b01:   backlog <= backlog - 1'b1;
        default: backlog <= backlog;
      endcase
    end
  end

  assign pendCount = backlog;
  assign pendAny   = (backlog != '0);
  assign refStall  = (backlog == FULL);
endmodule

// File: rtl/refresh_pacer.sv
module refresh_pacer
  import refresh_pacer_pkg::*;
#(
  parameter int CLK_PERIOD_NS    = 100,
  parameter int NORM_INTERVAL_NS = 7800,
  parameter int HOT_INTERVAL_NS  = 3900,
  parameter int MAX_PENDING      = 8,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          hotCase,
  input  logic          banksIdle,
  input  logic          refGrant,
  output logic          refReq,
  output logic [PW-1:0] pendCount,
  output logic          refStall
);
  pacerStrobes_t strobes;
  logic          pendAny;

  pacer_ctrl #(
    .CLK_PERIOD_NS(CLK_PERIOD_NS),
    .NORM_INTERVAL_NS(NORM_INTERVAL_NS),
    .HOT_INTERVAL_NS(HOT_INTERVAL_NS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .hotCase(hotCase), .banksIdle(banksIdle),
    .refGrant(refGrant), .pendAny(pendAny), .refReq(refReq), .strobes(strobes)
  );

  pacer_dp #(.MAX_PENDING(MAX_PENDING)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .pendCount(pendCount), .pendAny(pendAny), .refStall(refStall)
  );
endmodule

// File: rtl/pacer_chk.sv
module pacer_chk #(
  parameter int MAX_PENDING = 8,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input logic          clk,
  input logic          rstN,
  input logic          banksIdle,
  input logic          refGrant,
  input logic          refReq,
  input logic [PW-1:0] pendCount,
  input logic          refStall
);
  // R6
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    int'(pendCount) <= MAX_PENDING);

  // R4
  req_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (banksIdle && pendCount != '0));

  // R5
  no_silent_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(refGrant && refReq) |=> int'(pendCount) >= int'($past(pendCount)));

  // R1
  single_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> int'(pendCount) <= int'($past(pendCount)) + 1);

  // R7
  stall_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(refStall) |-> int'($past(pendCount)) == MAX_PENDING - 1);
endmodule

bind refresh_pacer pacer_chk #(.MAX_PENDING(MAX_PENDING)) uChk (
  .clk(clk), .rstN(rstN), .banksIdle(banksIdle), .refGrant(refGrant),
  .refReq(refReq), .pendCount(pendCount), .refStall(refStall)
);

// File: tb/sim_refresh_pacer.sv
module sim_refresh_pacer;
  localparam int CLK_P = 10;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, hotCase = 1'b0, banksIdle = 1'b0, refGrant = 1'b0;
  logic refReq, refStall;
  logic [PW-1:0] pendCount;

  int tests = 0, fails = 0, edgesDone = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  refresh_pacer u0 (
    .clk(clk), .rstN(rstN), .hotCase(hotCase), .banksIdle(banksIdle),
    .refGrant(refGrant), .refReq(refReq), .pendCount(pendCount), .refStall(refStall)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; hotCase = 1'b0; banksIdle = 1'b0; refGrant = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    edgesDone = 0;
  endtask

  task automatic goTo(input int target);
    repeat (target - edgesDone) @(posedge clk);
    edgesDone = target;
    @(negedge clk);
  endtask

  task automatic tReset();
    doReset();
    rstN = 1'b0; #1;
    check("R9 pend", pendCount, 0);
    check("R9 req", refReq, 0);
    check("R9 stall", refStall, 0);
    rstN = 1'b1;
  endtask

  task automatic tNormal();
    doReset();
    goTo(77);  check("R1 before first", pendCount, 0);
    goTo(78);  check("R1 first", pendCount, 1);
    goTo(155); check("R1 before second", pendCount, 1);
    goTo(156); check("R1 second", pendCount, 2);
  endtask

  task automatic tHot();
    doReset();
    hotCase = 1'b1;
    goTo(39); check("R2 before first", pendCount, 0);
    goTo(40); check("R2 first", pendCount, 1);
    goTo(78); check("R2 before second", pendCount, 1);
    goTo(79); check("R2 second", pendCount, 2);
  endtask

  task automatic tClamp();
    doReset();
    goTo(10);
    hotCase = 1'b1;
    goTo(49); check("R3 before clamped end", pendCount, 0);
    goTo(50); check("R3 clamped end", pendCount, 1);
  endtask

  task automatic tGrant();
    doReset();
    goTo(100);
    check("R4 busy banks", refReq, 0);
    banksIdle = 1'b1; #1;
    check("R4 idle banks", refReq, 1);
    refGrant = 1'b1;
    goTo(101);
    refGrant = 1'b0;
    check("R5 grant retires", pendCount, 0);
    check("R5 req drops when empty", refReq, 0);
    banksIdle = 1'b0;
    goTo(200);
    refGrant = 1'b1;
    goTo(201);
    refGrant = 1'b0;
    check("R5 grant without req ignored", pendCount, 1);
    goTo(220);
    banksIdle = 1'b1; #1;
    check("R5 req held until granted", refReq, 1);
    banksIdle = 1'b0;
  endtask

  task automatic tSaturate();
    doReset();
    goTo(623); check("R7 not full", refStall, 0);
    goTo(624); check("R6 eight owed", pendCount, 8);
    check("R7 stall when full", refStall, 1);
    goTo(702); check("R6 saturate", pendCount, 8);
    banksIdle = 1'b1; refGrant = 1'b1;
    goTo(703);
    refGrant = 1'b0; banksIdle = 1'b0;
    check("R5 grant from full", pendCount, 7);
    check("R7 stall clears", refStall, 0);
  endtask

  task automatic tCollide();
    doReset();
    goTo(155); check("R8 before collision", pendCount, 1);
    banksIdle = 1'b1; refGrant = 1'b1;
    goTo(156);
    refGrant = 1'b0;
    check("R8 tick with grant", pendCount, 1);
    check("R8 req still high", refReq, 1);
    banksIdle = 1'b0;
  endtask

  initial begin
    tReset();
    tNormal();
    tHot();
    tClamp();
    tGrant();
    tSaturate();
    tCollide();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule